// File: doc/BRIEF.md
# Bridge Reset Sequencing Controller

This block orders the resets and the configuration-access window of a two-port bus bridge. It runs on the upstream bus clock. It takes an active-low upstream reset that may change at any time, and a set of write strobes that software drives through the configuration register file: set and clear for the secondary-reset control bit, and set for the chip-reset diagnostic bit. From these it produces the downstream bus reset. It also produces a reset for the rest of the bridge's registers, a flag that says whether configuration cycles may be accepted, and a retry indication for cycles that arrive while access is closed.

The downstream pad controls come from the same logic. While the downstream reset is active, the control and grant pads float. The address/data, byte-enable and parity pads are held low, except during a chip reset, when every pad floats. Each new downstream reset period also produces one flush pulse, which empties the posted-write and delayed-transaction queues. A chip reset holds the bridge and the downstream bus in reset. It lets go a fixed number of clocks after two things are true: software has cleared the secondary-reset bit, and the external clock-mask loader reports that it is done.

Top module: `bridge_rst_seq`

## Requirements
- R1: Driving `rst_ni` low at once, with no clock edge needed, drives `dn_rst_no`, `core_rst_no` and `cfg_ok_o` low and clears `sec_bit_o` and `chip_bit_o`.
- R2: After `rst_ni` rises between clock edges, `dn_rst_no` and `core_rst_no` go high after the 2nd rising edge. `cfg_ok_o` stays low through the 17th edge and goes high after the 18th edge (a 2-stage synchronizer followed by a 16-clock guard window).
- R3: A pulse on `sec_set_i` sets `sec_bit_o` and drives `dn_rst_no` low after that edge. Both hold until a pulse on `sec_clr_i`. When both strobes arrive in the same cycle, the clear wins.
- R4: A downstream reset that comes only from the secondary-reset bit leaves `cfg_ok_o` high and `cfg_retry_o` low.
- R5: The pad enables follow three cases. With no downstream reset, `dn_ctl_oe_o`=1 and `dn_lowdrive_o`=0. During a downstream reset outside a chip reset, `dn_ctl_oe_o`=0 and `dn_lowdrive_o`=1. During a chip reset both are 0.
- R6: `flush_o` is high for exactly the first cycle of each downstream reset period started by either bit. It stays low when `rst_ni` asserts.
- R7: A pulse on `chip_set_i` while `cfg_ok_o` is high sets both `chip_bit_o` and `sec_bit_o`. It drives `dn_rst_no`, `core_rst_no` and `cfg_ok_o` low after that edge.
- R8: `chip_bit_o` clears on the 20th consecutive rising edge at which `sec_bit_o` is 0 and `mask_done_i` is 1. If either condition lapses, the count restarts from zero. The bit holds while either condition is unmet.
- R9: `cfg_retry_o` equals `cfg_req_i` while `cfg_ok_o` is low, and is 0 while `cfg_ok_o` is high.
- R10: The strobes have no effect while the synchronized reset is low. `chip_set_i` has no effect while `cfg_ok_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Upstream bus clock |
| rst_ni | input | 1 | Upstream reset, active low, asynchronous |
| sec_set_i | input | 1 | Config write strobe: set secondary-reset bit |
| sec_clr_i | input | 1 | Config write strobe: clear secondary-reset bit |
| chip_set_i | input | 1 | Config write strobe: set chip-reset bit |
| mask_done_i | input | 1 | Clock-mask shift loader finished |
| cfg_req_i | input | 1 | A configuration cycle is presented |
| dn_rst_no | output | 1 | Downstream bus reset, active low |
| core_rst_no | output | 1 | Reset for bridge registers, active low |
| cfg_ok_o | output | 1 | Configuration cycles may be accepted |
| cfg_retry_o | output | 1 | Presented configuration cycle must be retried |
| dn_ctl_oe_o | output | 1 | Drive enable for downstream control and grant pads |
| dn_lowdrive_o | output | 1 | Hold address/data, byte-enable and parity pads low |
| flush_o | output | 1 | One-cycle flush of posted and delayed queues |
| sec_bit_o | output | 1 | Current secondary-reset bit |
| chip_bit_o | output | 1 | Current chip-reset bit |

## Verification
Each state bit reaches a port directly, and every pad enable is decoded from these bits without delay. A wrong secondary-reset or chip-reset bit therefore appears on `dn_rst_no`, the pad enables and `cfg_ok_o` in the first cycle after the edge that corrupted it. A guard or release counter that is off by one moves the rise of `cfg_ok_o`, or the fall of `chip_bit_o`, by one clock; the bench samples those edges exactly. A wrong flush history shows up as a missing, doubled or extra `flush_o` pulse at the start of a reset period.

// File: rtl/bridge_rst_pkg.sv
package bridge_rst_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned GUARD_CYC_DEF   = 16;
  localparam int unsigned REL_CYC_DEF     = 20;

  typedef enum logic [1:0] {
    PAD_ACTIVE = 2'd0,
    PAD_LOW    = 2'd1,
    PAD_HIZ    = 2'd2
  } pad_mode_e;
endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] stg_q;

  // assert asynchronously, release through STAGES flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = stg_q[STAGES-1];
endmodule

// File: rtl/brs_guard.sv
module brs_guard #(
  parameter int unsigned CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic open_o
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q == LAST);
endmodule

// File: rtl/brs_ctl_bits.sv
module brs_ctl_bits #(
  parameter int unsigned REL_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_set_i,
  input  logic sec_clr_i,
  input  logic chip_go_i,
  input  logic mask_done_i,
  output logic sec_bit_o,
  output logic chip_bit_o
);
  localparam int unsigned RW = $clog2(REL_CYC);
  localparam logic [RW-1:0] LAST = RW'(REL_CYC - 1);

  logic          sec_q, chip_q;
  logic [RW-1:0] rel_q;
  logic          rel_arm;

  assign rel_arm = chip_q && !sec_q && mask_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sec_q <= 1'b0;
    else if (chip_go_i) sec_q <= 1'b1;
    else if (sec_clr_i) sec_q <= 1'b0;
    else if (sec_set_i) sec_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_q <= 1'b0;
      rel_q  <= '0;
    end else if (chip_go_i) begin
      chip_q <= 1'b1;
      rel_q  <= '0;
    end else if (rel_arm) begin
      if (rel_q == LAST) begin
        chip_q <= 1'b0;
        rel_q  <= '0;
      end else begin
        rel_q  <= rel_q + 1'b1;
      end
    end else begin
      rel_q <= '0;
    end
  end

  assign sec_bit_o  = sec_q;
  assign chip_bit_o = chip_q;
endmodule

// File: rtl/bridge_rst_seq.sv
module bridge_rst_seq
  import bridge_rst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned GUARD_CYC   = GUARD_CYC_DEF,
  parameter int unsigned REL_CYC     = REL_CYC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_set_i,
  input  logic sec_clr_i,
  input  logic chip_set_i,
  input  logic mask_done_i,
  input  logic cfg_req_i,
  output logic dn_rst_no,
  output logic core_rst_no,
  output logic cfg_ok_o,
  output logic cfg_retry_o,
  output logic dn_ctl_oe_o,
  output logic dn_lowdrive_o,
  output logic flush_o,
  output logic sec_bit_o,
  output logic chip_bit_o
);
  logic      rst_sync_n;
  logic      guard_open;
  logic      sec_bit, chip_bit;
  logic      dn_act, dn_act_q;
  logic      chip_go;
  pad_mode_e pad_mode;

  brs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  brs_guard #(.CYC(GUARD_CYC)) u_guard (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .open_o(guard_open)
  );

  assign cfg_ok_o = guard_open && !chip_bit;
  assign chip_go  = chip_set_i && cfg_ok_o;

  brs_ctl_bits #(.REL_CYC(REL_CYC)) u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .sec_set_i  (sec_set_i),
    .sec_clr_i  (sec_clr_i),
    .chip_go_i  (chip_go),
    .mask_done_i(mask_done_i),
    .sec_bit_o  (sec_bit),
    .chip_bit_o (chip_bit)
  );

  assign dn_act = !rst_sync_n || sec_bit || chip_bit;

  // history starts high so upstream reset raises no flush
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) dn_act_q <= 1'b1;
    else             dn_act_q <= dn_act;
  end

  always_comb begin
    if (!dn_act)      pad_mode = PAD_ACTIVE;
    else if (chip_bit) pad_mode = PAD_HIZ;
    else              pad_mode = PAD_LOW;
  end

  assign flush_o       = dn_act && !dn_act_q;
  assign dn_rst_no     = !dn_act;
  assign core_rst_no   = rst_sync_n && !chip_bit;
  assign cfg_retry_o   = cfg_req_i && !cfg_ok_o;
  assign dn_ctl_oe_o   = (pad_mode == PAD_ACTIVE);
  assign dn_lowdrive_o = (pad_mode == PAD_LOW);
  assign sec_bit_o     = sec_bit;
  assign chip_bit_o    = chip_bit;
endmodule

// File: rtl/bridge_rst_seq_chk.sv
module bridge_rst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_req_i,
  input logic mask_done_i,
  input logic dn_rst_no,
  input logic cfg_ok_o,
  input logic cfg_retry_o,
  input logic dn_ctl_oe_o,
  input logic dn_lowdrive_o,
  input logic flush_o,
  input logic sec_bit_o,
  input logic chip_bit_o
);
  AST_UP_RST_HOLDS: assert property (@(posedge clk_i)
    !rst_ni |-> (!dn_rst_no && !cfg_ok_o)); // R1
  AST_SEC_HOLDS_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_bit_o |-> !dn_rst_no); // R3
  AST_SEC_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_bit_o && !chip_bit_o && $past(cfg_ok_o)) |-> cfg_ok_o); // R4
  AST_PAD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dn_ctl_oe_o && dn_lowdrive_o)); // R5
  AST_PAD_OFF_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dn_rst_no |-> !dn_ctl_oe_o); // R5
  AST_FLUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R6
  AST_FLUSH_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dn_rst_no) |-> flush_o); // R6
  AST_CHIP_SETS_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_bit_o) |-> sec_bit_o); // R7
  AST_CHIP_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_bit_o |-> (!cfg_ok_o && !dn_lowdrive_o)); // R7
  AST_CHIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_bit_o && (sec_bit_o || !mask_done_i)) |=> chip_bit_o); // R8
  AST_RETRY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ok_o || !cfg_req_i) |-> !cfg_retry_o); // R9
endmodule

bind bridge_rst_seq bridge_rst_seq_chk u_chk (.*);

// File: tb/bridge_rst_seq_tb_top.sv
`timescale 1ns/1ps
module bridge_rst_seq_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic sec_set = 1'b0, sec_clr = 1'b0, chip_set = 1'b0, mask_done = 1'b0, cfg_req = 1'b0;
  logic dn_rst_n, core_rst_n, cfg_ok, cfg_retry, ctl_oe, lowdrive, flush, sec_bit, chip_bit;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  bridge_rst_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sec_set_i(sec_set), .sec_clr_i(sec_clr),
    .chip_set_i(chip_set), .mask_done_i(mask_done), .cfg_req_i(cfg_req),
    .dn_rst_no(dn_rst_n), .core_rst_no(core_rst_n), .cfg_ok_o(cfg_ok),
    .cfg_retry_o(cfg_retry), .dn_ctl_oe_o(ctl_oe), .dn_lowdrive_o(lowdrive),
    .flush_o(flush), .sec_bit_o(sec_bit), .chip_bit_o(chip_bit)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {sec_set, sec_clr, req, exp dn_rst_n, exp cfg_ok, exp retry, exp flush, exp lowdrive}
  localparam logic [7:0] VEC [8] = '{
    8'b001_11000,  // idle, access open
    8'b101_01011,  // R3 set: reset, flush, low drive; R4 cfg stays open
    8'b001_01001,  // R6 flush gone, R4 no retry
    8'b100_01001,  // set again: no new flush
    8'b010_11000,  // R3 clear releases
    8'b110_11000,  // R3 clear wins over set
    8'b100_01011,  // new period: new flush
    8'b010_11000   // release
  };

  initial begin
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1", "dn_rst_n async", dn_rst_n, 1'b0);
    chk("R1", "cfg_ok async", cfg_ok, 1'b0);
    chk("R1", "core_rst_n async", core_rst_n, 1'b0);
    repeat (3) tick();
    chk("R5", "lowdrive in up reset", lowdrive, 1'b1);
    chk("R5", "oe in up reset", ctl_oe, 1'b0);
    chk("R6", "no flush in up reset", flush, 1'b0);
    cfg_req = 1'b1;
    #0.5;
    chk("R9", "retry while closed", cfg_retry, 1'b1);

    // release and count edges; strobes in the sync window are ignored
    rst_ni = 1'b1;
    sec_set = 1'b1;
    tick();
    sec_set = 1'b0;
    chk("R2", "dn_rst_n after 1 edge", dn_rst_n, 1'b0);
    tick();
    chk("R2", "dn_rst_n after 2 edges", dn_rst_n, 1'b1);
    chk("R10", "sec set in sync window", sec_bit, 1'b0);
    chk("R2", "core_rst_n after 2 edges", core_rst_n, 1'b1);
    chip_set = 1'b1;
    tick();
    chip_set = 1'b0;
    chk("R10", "chip set while closed", chip_bit, 1'b0);
    repeat (14) tick();
    chk("R2", "cfg_ok after 17 edges", cfg_ok, 1'b0);
    tick();
    chk("R2", "cfg_ok after 18 edges", cfg_ok, 1'b1);
    chk("R9", "no retry when open", cfg_retry, 1'b0);

    for (int i = 0; i < 8; i++) begin
      {sec_set, sec_clr, cfg_req} = VEC[i][7:5];
      tick();
      sec_set = 1'b0;
      sec_clr = 1'b0;
      chk("R3", $sformatf("vec %0d dn_rst_n", i), dn_rst_n, VEC[i][4]);
      chk("R4", $sformatf("vec %0d cfg_ok", i), cfg_ok, VEC[i][3]);
      chk("R9", $sformatf("vec %0d retry", i), cfg_retry, VEC[i][2]);
      chk("R6", $sformatf("vec %0d flush", i), flush, VEC[i][1]);
      chk("R5", $sformatf("vec %0d lowdrive", i), lowdrive, VEC[i][0]);
      chk("R5", $sformatf("vec %0d oe", i), ctl_oe, VEC[i][4]);
    end

    // chip reset
    cfg_req = 1'b1;
    chip_set = 1'b1;
    tick();
    chip_set = 1'b0;
    chk("R7", "chip bit", chip_bit, 1'b1);
    chk("R7", "sec bit auto set", sec_bit, 1'b1);
    chk("R7", "dn_rst_n", dn_rst_n, 1'b0);
    chk("R7", "core_rst_n", core_rst_n, 1'b0);
    chk("R7", "cfg_ok", cfg_ok, 1'b0);
    chk("R9", "retry in chip reset", cfg_retry, 1'b1);
    chk("R6", "flush on chip reset", flush, 1'b1);
    chk("R5", "hiz lowdrive", lowdrive, 1'b0);
    chk("R5", "hiz oe", ctl_oe, 1'b0);
    repeat (30) tick();
    chk("R8", "hold with sec set", chip_bit, 1'b1);
    sec_clr = 1'b1;
    tick();
    sec_clr = 1'b0;
    repeat (25) tick();
    chk("R8", "hold without mask done", chip_bit, 1'b1);
    chk("R8", "dn held", dn_rst_n, 1'b0);
    mask_done = 1'b1;
    repeat (10) tick();
    mask_done = 1'b0;
    tick();
    mask_done = 1'b1;
    repeat (19) tick();
    chk("R8", "still set after 19 edges", chip_bit, 1'b1);
    tick();
    chk("R8", "cleared on 20th edge", chip_bit, 1'b0);
    chk("R8", "dn released", dn_rst_n, 1'b1);
    chk("R8", "core released", core_rst_n, 1'b1);
    chk("R8", "cfg_ok back", cfg_ok, 1'b1);
    chk("R6", "no flush on release", flush, 1'b0);

    // upstream reset mid-run with sec bit set
    sec_set = 1'b1;
    tick();
    sec_set = 1'b0;
    #0.5 rst_ni = 1'b0;
    #0.5;
    chk("R1", "sec bit cleared async", sec_bit, 1'b0);
    chk("R1", "cfg_ok dropped async", cfg_ok, 1'b0);
    chk("R6", "no flush on up reset", flush, 1'b0);
    tick();
    rst_ni = 1'b1;
    repeat (2) tick();
    chk("R1", "dn released after re-sync", dn_rst_n, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule